// File: doc/BRIEF.md
# Unsigned Byte Load Unit

This block carries out one unsigned byte load for a small 32-bit load/store stage. When a valid strobe arrives with a byte-load instruction word, it forms the effective address from the two operand values. The normal mode adds the operands. The extended mode joins them into a 64-bit address, with the first operand in the upper half. The block then picks the addressed byte out of the 32-bit word that memory returns. The pick follows the current endianness, and it flips that endianness when the instruction asks for a byte-reversed access. The byte is zero-extended into the destination register.

The caller supplies three verdicts for the current access: the translation lookup result, the zone-protection check and the physical-address-extension policy. The block arbitrates among three exceptions in a fixed priority. When one of them is taken, it reports a five-bit exception code. It also hands back updated machine status bits: the user-mode and virtual-mode bits are saved into their shadow copies and then cleared. All results are registered and appear one cycle after the strobe, together with a done pulse.

Top module: `byte_load_unit`

## Requirements
- R1: A strobe is acted on only when instruction bits 31:26 equal 110000. Any other opcode gives no done pulse, no write and no exception.
- R2: With the extended bit (instruction bit 7) clear, memAddr is zero in its upper 32 bits and opA+opB (modulo 2^32) in its lower 32 bits. With the bit set, memAddr is {opA, opB} and no addition takes place.
- R3: The byte lane is memAddr[1:0]. Access is big-endian when endLittle equals the reverse bit (instruction bit 9), and little-endian otherwise. In big-endian access, lane 0 reads memWord[31:24] and lane 3 reads memWord[7:0]. In little-endian access, lane 0 reads memWord[7:0] and lane 3 reads memWord[31:24].
- R4: A load that completes without an exception raises rdWe. It returns the selected byte in rdData[7:0] with rdData[31:8] zero, and rdIdx equal to instruction bits 25:21.
- R5: done is a one-cycle pulse in the cycle after an accepted strobe. Each done carries exactly one of rdWe and excValid.
- R6: When the extended bit is set, paeOn is 1 and eaAllowed is 0, a privileged-instruction exception with code 00111 is raised.
- R7: When curVm is 1 and tlbHit is 0, a translation-miss exception with code 10010 is raised.
- R8: When curVm and curUm are both 1, tlbHit is 1 and zoneBlock is 1, a storage exception with code 10000 is raised. zoneBlock has no effect when curUm or curVm is 0.
- R9: The priority is privileged first, then translation miss, then storage. Only one code is reported per instruction.
- R10: On any exception, nxtUms takes curUm and nxtVms takes curVm, while nxtUm and nxtVm are 0. Without an exception, the four nxt bits copy the cur bits.
- R11: During and right after reset, done, rdWe, excValid, rdIdx, rdData, excCode and the nxt status bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| opA | input | 32 | First operand value |
| opB | input | 32 | Second operand value |
| memWord | input | 32 | Memory word read at memAddr |
| tlbHit | input | 1 | A valid translation exists |
| zoneBlock | input | 1 | Zone protection forbids the access |
| endLittle | input | 1 | Current endianness is little |
| paeOn | input | 1 | Physical address extension enabled |
| eaAllowed | input | 1 | Extended access explicitly permitted |
| curUm | input | 1 | Current user-mode bit |
| curVm | input | 1 | Current virtual-mode bit |
| curUms | input | 1 | Current saved user-mode bit |
| curVms | input | 1 | Current saved virtual-mode bit |
| memAddr | output | 64 | Effective address (combinational) |
| done | output | 1 | Completion pulse |
| rdWe | output | 1 | Destination write enable |
| rdIdx | output | 5 | Destination register index |
| rdData | output | 32 | Zero-extended byte |
| excValid | output | 1 | Exception taken |
| excCode | output | 5 | Exception code |
| nxtUm | output | 1 | Updated user-mode bit |
| nxtVm | output | 1 | Updated virtual-mode bit |
| nxtUms | output | 1 | Updated saved user-mode bit |
| nxtVms | output | 1 | Updated saved virtual-mode bit |

## Verification
The bench exercises every pairing of endianness and reverse bit, with the lane moved across the word. A design that inverted the lane order or ignored the reverse bit would return a neighbouring byte. It stacks exception conditions so that the privileged check has to beat a pending translation miss, and it holds zoneBlock high while user mode or virtual mode is off. A broken arbiter would then report the wrong code, or would fault a load that should write rdData. It also sends a near-miss opcode and places non-default values in the saved status bits. A design that decoded the opcode loosely would pulse done, and a design that swapped the save order would return the wrong shadow bits.

// File: rtl/blu_pkg.sv
package blu_pkg;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_PRIV  = 2'd1,
    EXC_TLB   = 2'd2,
    EXC_STORE = 2'd3
  } excKind_e;

  typedef struct packed {
    logic     fire;
    logic     writeRd;
    logic     takeExc;
    excKind_e kind;
  } ctrlStrobe_t;

  localparam int          OPC_W    = 6;
  localparam int          EC_W     = 5;
  localparam logic [5:0]  OPC_LBU  = 6'b110000;
  localparam logic [4:0]  EC_PRIV  = 5'b00111;
  localparam logic [4:0]  EC_TLB   = 5'b10010;
  localparam logic [4:0]  EC_STORE = 5'b10000;

endpackage

// File: rtl/blu_ctrl.sv
module blu_ctrl
  import blu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               valid,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               eaBit,
  input  logic               paeOn,
  input  logic               eaAllowed,
  input  logic               tlbHit,
  input  logic               zoneBlock,
  input  logic               curUm,
  input  logic               curVm,
  output ctrlStrobe_t        strobe
);

  logic accept;
  logic privHit;
  logic missHit;
  logic storeHit;
  excKind_e kindSel;

  assign accept   = valid && (opcode == OPC_LBU);
  assign privHit  = eaBit && paeOn && !eaAllowed;
  assign missHit  = curVm && !tlbHit;
  assign storeHit = curVm && curUm && tlbHit && zoneBlock;

  // fixed arbitration: privileged, then translation miss, then storage
  always_comb begin
    if (privHit)       kindSel = EXC_PRIV;
    else if (missHit)  kindSel = EXC_TLB;
    else if (storeHit) kindSel = EXC_STORE;
    else               kindSel = EXC_NONE;
  end

  always_comb begin
    strobe.fire    = accept;
    strobe.kind    = accept ? kindSel : EXC_NONE;
    strobe.takeExc = accept && (kindSel != EXC_NONE);
    strobe.writeRd = accept && (kindSel == EXC_NONE);
  end

  p_exc_needs_fire_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeExc || strobe.writeRd) |-> (valid && opcode == OPC_LBU));

  p_store_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == EXC_STORE) |-> (curUm && curVm && tlbHit && !privHit));

  p_priv_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && eaBit && paeOn && !eaAllowed) |-> (strobe.kind == EXC_PRIV));

endmodule

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [REG_IDX_W-1:0]  rdSel,
  input  logic                  revBit,
  input  logic                  eaBit,
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  logic [WORD_W-1:0]     memWord,
  input  logic                  endLittle,
  input  logic                  curUm,
  input  logic                  curVm,
  input  logic                  curUms,
  input  logic                  curVms,
  output logic [2*WORD_W-1:0]   memAddr,
  output logic                  done,
  output logic                  rdWe,
  output logic [REG_IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0]     rdData,
  output logic                  excValid,
  output logic [EC_W-1:0]       excCode,
  output logic                  nxtUm,
  output logic                  nxtVm,
  output logic                  nxtUms,
  output logic                  nxtVms
);

  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] sumAddr;
  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] wordLane;
  logic              bigEff;
  logic [7:0]        laneBytes [LANES];
  logic [7:0]        pickByte;
  logic [EC_W-1:0]   codeSel;

  assign sumAddr = opA + opB;
  assign memAddr = eaBit ? {opA, opB} : {{WORD_W{1'b0}}, sumAddr};

  assign lane     = memAddr[LANE_W-1:0];
  assign bigEff   = (endLittle == revBit);
  assign wordLane = bigEff ? LANE_W'(LANES - 1 - int'(lane)) : lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBytes[g] = memWord[8*g +: 8];
  end

  assign pickByte = laneBytes[wordLane];

  always_comb begin
    unique case (strobe.kind)
      EXC_PRIV:  codeSel = EC_PRIV;
      EXC_TLB:   codeSel = EC_TLB;
      EXC_STORE: codeSel = EC_STORE;
      default:   codeSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done     <= 1'b0;
      rdWe     <= 1'b0;
      rdIdx    <= '0;
      rdData   <= '0;
      excValid <= 1'b0;
      excCode  <= '0;
      nxtUm    <= 1'b0;
      nxtVm    <= 1'b0;
      nxtUms   <= 1'b0;
      nxtVms   <= 1'b0;
    end else begin
      done     <= strobe.fire;
      rdWe     <= strobe.writeRd;
      excValid <= strobe.takeExc;
      if (strobe.fire) begin
        excCode <= codeSel;
        if (strobe.writeRd) begin
          rdIdx  <= rdSel;
          rdData <= {{(WORD_W-8){1'b0}}, pickByte};
        end
        if (strobe.takeExc) begin
          nxtUms <= curUm;
          nxtVms <= curVm;
          nxtUm  <= 1'b0;
          nxtVm  <= 1'b0;
        end else begin
          nxtUms <= curUms;
          nxtVms <= curVms;
          nxtUm  <= curUm;
          nxtVm  <= curVm;
        end
      end
    end
  end

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdWe ^ excValid));

  p_done_after_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strobe.fire));

  p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdWe |-> (rdData[WORD_W-1:8] == '0));

  p_mode_cleared_r10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (!nxtUm && !nxtVm && nxtUms == $past(curUm) && nxtVms == $past(curVm)));

  p_code_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excCode != '0));

endmodule

// File: rtl/byte_load_unit.sv
module byte_load_unit
  import blu_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  valid,
  input  logic [31:0]           instr,
  input  logic [WORD_W-1:0]     opA,
  input  logic [WORD_W-1:0]     opB,
  input  logic [WORD_W-1:0]     memWord,
  input  logic                  tlbHit,
  input  logic                  zoneBlock,
  input  logic                  endLittle,
  input  logic                  paeOn,
  input  logic                  eaAllowed,
  input  logic                  curUm,
  input  logic                  curVm,
  input  logic                  curUms,
  input  logic                  curVms,
  output logic [2*WORD_W-1:0]   memAddr,
  output logic                  done,
  output logic                  rdWe,
  output logic [REG_IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0]     rdData,
  output logic                  excValid,
  output logic [EC_W-1:0]       excCode,
  output logic                  nxtUm,
  output logic                  nxtVm,
  output logic                  nxtUms,
  output logic                  nxtVms
);

  ctrlStrobe_t strobe;
  logic [OPC_W-1:0] opcode;
  logic [REG_IDX_W-1:0] rdSel;
  logic revBit;
  logic eaBit;

  assign opcode = instr[31:26];
  assign rdSel  = instr[21 +: REG_IDX_W];
  assign revBit = instr[9];
  assign eaBit  = instr[7];

  blu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .valid     (valid),
    .opcode    (opcode),
    .eaBit     (eaBit),
    .paeOn     (paeOn),
    .eaAllowed (eaAllowed),
    .tlbHit    (tlbHit),
    .zoneBlock (zoneBlock),
    .curUm     (curUm),
    .curVm     (curVm),
    .strobe    (strobe)
  );

  blu_datapath #(
    .WORD_W    (WORD_W),
    .REG_IDX_W (REG_IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .revBit    (revBit),
    .eaBit     (eaBit),
    .opA       (opA),
    .opB       (opB),
    .memWord   (memWord),
    .endLittle (endLittle),
    .curUm     (curUm),
    .curVm     (curVm),
    .curUms    (curUms),
    .curVms    (curVms),
    .memAddr   (memAddr),
    .done      (done),
    .rdWe      (rdWe),
    .rdIdx     (rdIdx),
    .rdData    (rdData),
    .excValid  (excValid),
    .excCode   (excCode),
    .nxtUm     (nxtUm),
    .nxtVm     (nxtVm),
    .nxtUms    (nxtUms),
    .nxtVms    (nxtVms)
  );

endmodule

// File: tb/tb_byte_load_unit.sv
`timescale 1ns/1ps
module tb_byte_load_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opA = '0, opB = '0, memWord = '0;
  logic        tlbHit = 1'b0, zoneBlock = 1'b0, endLittle = 1'b0;
  logic        paeOn = 1'b0, eaAllowed = 1'b0;
  logic        curUm = 1'b0, curVm = 1'b0, curUms = 1'b0, curVms = 1'b0;
  logic [63:0] memAddr;
  logic        done, rdWe, excValid;
  logic [4:0]  rdIdx, excCode;
  logic [31:0] rdData;
  logic        nxtUm, nxtVm, nxtUms, nxtVms;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_load_unit dut (
    .clk(clk), .rstN(rstN), .valid(valid), .instr(instr), .opA(opA), .opB(opB),
    .memWord(memWord), .tlbHit(tlbHit), .zoneBlock(zoneBlock), .endLittle(endLittle),
    .paeOn(paeOn), .eaAllowed(eaAllowed), .curUm(curUm), .curVm(curVm),
    .curUms(curUms), .curVms(curVms), .memAddr(memAddr), .done(done), .rdWe(rdWe),
    .rdIdx(rdIdx), .rdData(rdData), .excValid(excValid), .excCode(excCode),
    .nxtUm(nxtUm), .nxtVm(nxtVm), .nxtUms(nxtUms), .nxtVms(nxtVms)
  );

  typedef struct packed {
    logic        r;
    logic        ea;
    logic [4:0]  rd;
    logic [31:0] a;
    logic [31:0] b;
    logic        endL;
    logic        pae;
    logic        allow;
    logic        tlb;
    logic        zone;
    logic        um;
    logic        vm;
    logic [7:0]  expByte;
    logic [4:0]  expCode;
  } vec_t;

  localparam int NV = 12;
  localparam logic [31:0] WORD = 32'hA1B2C3D4;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,5'd5, 32'h100,      32'h1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hB2, 5'b00000},
    '{1'b0,1'b0,5'd6, 32'h10,       32'h3, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hD4, 5'b00000},
    '{1'b1,1'b0,5'd7, 32'h20,       32'h0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hD4, 5'b00000},
    '{1'b0,1'b0,5'd8, 32'h2,        32'h0, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hB2, 5'b00000},
    '{1'b1,1'b0,5'd9, 32'h2,        32'h0, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hC3, 5'b00000},
    '{1'b0,1'b1,5'd10,32'hDEAD0000, 32'h1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hB2, 5'b00000},
    '{1'b0,1'b1,5'd11,32'h12340000, 32'h3, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'hD4, 5'b00000},
    '{1'b0,1'b1,5'd12,32'h12340000, 32'h3, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00, 5'b00111},
    '{1'b0,1'b0,5'd13,32'h40,       32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 5'b10010},
    '{1'b0,1'b0,5'd14,32'h40,       32'h0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h00, 5'b10000},
    '{1'b0,1'b0,5'd15,32'h4,        32'h0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 8'hA1, 5'b00000},
    '{1'b0,1'b0,5'd16,32'h8,        32'h0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 8'hA1, 5'b00000}
  };

  function automatic logic [31:0] mkInstr(logic [5:0] opc, logic r, logic ea, logic [4:0] rd);
    return {opc, rd, 5'd1, 5'd2, 1'b0, r, 1'b0, ea, 7'b0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 done", {63'b0, done}, 64'd0);
    chk("R11 rdData", {32'b0, rdData}, 64'd0);
    chk("R11 status", {60'b0, nxtUm, nxtVm, nxtUms, nxtVms}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 after release", {54'b0, done, rdWe, excValid, rdIdx, excCode}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] expAddr;
      logic isExc;
      v = VECS[i];
      instr = mkInstr(6'b110000, v.r, v.ea, v.rd);
      opA = v.a; opB = v.b; memWord = WORD;
      endLittle = v.endL; paeOn = v.pae; eaAllowed = v.allow;
      tlbHit = v.tlb; zoneBlock = v.zone; curUm = v.um; curVm = v.vm;
      curUms = ~v.um; curVms = 1'b1;
      valid = 1'b1;
      #1;
      expAddr = v.ea ? {v.a, v.b} : {32'b0, v.a + v.b};
      chk("R2 memAddr", memAddr, expAddr);
      @(posedge clk); #1;
      valid = 1'b0;
      isExc = (v.expCode != 5'd0);
      chk("R5 done", {63'b0, done}, 64'd1);
      chk("R5 outcome", {62'b0, rdWe, excValid}, {62'b0, !isExc, isExc});
      if (isExc) begin
        chk("R6 R7 R8 R9 code", {59'b0, excCode}, {59'b0, v.expCode});
        chk("R10 status exc", {60'b0, nxtUm, nxtVm, nxtUms, nxtVms},
            {60'b0, 1'b0, 1'b0, v.um, v.vm});
      end else begin
        chk("R3 R4 rdData", {32'b0, rdData}, {56'b0, v.expByte});
        chk("R4 rdIdx", {59'b0, rdIdx}, {59'b0, v.rd});
        chk("R10 status pass", {60'b0, nxtUm, nxtVm, nxtUms, nxtVms},
            {60'b0, v.um, v.vm, ~v.um, 1'b1});
      end
      @(posedge clk); #1;
      chk("R5 single pulse", {63'b0, done}, 64'd0);
    end

    // R1: near-miss opcode ignored
    instr = mkInstr(6'b110001, 1'b0, 1'b0, 5'd3);
    opA = 32'h0; opB = 32'h0; curVm = 1'b1; tlbHit = 1'b0; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0;
    chk("R1 bad opcode", {61'b0, done, rdWe, excValid}, 64'd0);

    // R4 R5: back-to-back loads
    curVm = 1'b0; curUm = 1'b0; tlbHit = 1'b1; endLittle = 1'b0;
    instr = mkInstr(6'b110000, 1'b0, 1'b0, 5'd20);
    opA = 32'h7; opB = 32'h0; memWord = 32'h11223344; valid = 1'b1;
    @(posedge clk); #1;
    chk("R4 b2b first", {32'b0, rdData}, 64'h44);
    opA = 32'h5;
    @(posedge clk); #1;
    valid = 1'b0;
    chk("R4 b2b second", {32'b0, rdData}, 64'h22);
    chk("R5 b2b done", {63'b0, done}, 64'd1);

    summary();
  end

endmodule